// File: doc/BRIEF.md
# Manchester-to-UART Reformatting Bridge

The bridge takes a single-wire Manchester stream, in which clock and data share the line, and recovers its bits by sampling the line once per system clock at a fixed number of samples per bit. It then watches the recovered bit stream for a configurable block-start byte. Until that byte is seen, nothing is kept. From the matching byte onward, every group of eight bits forms a word. Each word goes into a small internal word FIFO. The FIFO feeds an asynchronous transmitter that sends each word as a standard 8N1 character.

Words arrive most-significant bit first on the Manchester side and leave least-significant bit first on the UART side, so a normal UART receiver reads back the same byte value. A code violation is a missing mid-bit transition, which includes the end of a block when the line goes quiet. A violation ends the block, throws away any partly assembled word, and restarts the search for the start byte.

Inside the block, the FIFO passes words to the transmitter over a valid/ready handshake. The transmitter raises ready only while it is idle. A word stays at the FIFO head until the transmitter accepts it. There is no back-pressure toward the line, because the line cannot be paused. A word that arrives while the FIFO is full is therefore dropped, and this is recorded.

Top module: `mdu_bridge`

## Requirements
- R1: After reset, `utx` is high and `sync_found`, `overflow` and `busy` are all low.
- R2: The line is sampled OVS (16) times per bit. A low-to-high transition at mid-bit decodes as 1, and a high-to-low transition decodes as 0. Transitions at bit boundaries are ignored. The first received bit of each word is its most significant bit.
- R3: No word is output until an 8-bit window of received bits equals `start_pattern`. That matching byte is the first word output. Each following group of 8 bits is the next word.
- R4: `sync_found` rises after the start byte is matched and stays high while valid bits keep arriving.
- R5: If no mid-bit transition occurs within 1.5 bit times of the previous one, a code violation occurs. A violation clears `sync_found`, discards the partly assembled word, and restarts the start-byte search.
- R6: Each word is sent on `utx` as one character with the following layout, each cell lasting BAUD_DIV (32) clocks:
  - one low start cell;
  - 8 data cells, bit 0 first;
  - one high stop cell.
- R7: The FIFO holds up to FIFO_DEPTH (16) words. Words leave in the order they were received.
- R8: A word that arrives while the FIFO is full is discarded. The same event sets `overflow`, which then stays high until reset.
- R9: `busy` is high while the FIFO holds a word or a character is being sent, and low otherwise. `utx` is high whenever `busy` is low.
- R10: A block whose start byte differs from `start_pattern` produces no output and does not raise `sync_found`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and system clock (OVS samples per Manchester bit) |
| rst_n | input | 1 | Active-low asynchronous reset |
| mline | input | 1 | Manchester-encoded serial input |
| start_pattern | input | WORD_W | Byte that marks the first word of a block |
| utx | output | 1 | UART transmit line, idles high |
| sync_found | output | 1 | High while a block is being received after its start byte |
| overflow | output | 1 | Sticky flag set when a word is dropped because the FIFO is full |
| busy | output | 1 | High while words are queued or a character is in flight |

## Verification
The decoder produces a bit about three clocks after that bit's mid-bit transition, and the finished word reaches the FIFO two clocks later. The transmitter starts a character within a few clocks after that. Because these latencies are short and fixed, the monitor does not predict start times. Instead it triggers on each falling `utx` edge seen at a negative clock edge and samples every cell at its centre, BAUD_DIV clocks apart. Flags are read only after margins many times longer than the pipeline depth: `sync_found` at the end of a byte, its clearing 64 idle clocks after a block ends, and `busy` and `overflow` only once the queue has drained.

// File: rtl/mdu_bridge_pkg.sv
package mdu_bridge_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/mdu_man_decoder.sv
module mdu_man_decoder #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic bit_valid,
  output logic bit_val,
  output logic viol
);
  localparam int CW = $clog2(2 * OVS + 1);
  localparam logic [CW-1:0] EARLY = CW'((3 * OVS) / 4);
  localparam logic [CW-1:0] LATE  = CW'((5 * OVS) / 4);
  localparam logic [CW-1:0] VIOLC = CW'((3 * OVS) / 2);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          locked;
  logic          seen;
  logic [CW-1:0] cnt;
  logic          tog;
  logic          lvl;

  assign lvl = sync_q[1];
  assign tog = sync_q[1] ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      prev_q    <= 1'b0;
      locked    <= 1'b0;
      seen      <= 1'b0;
      cnt       <= '0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
      viol      <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], line_i};
      prev_q    <= sync_q[1];
      bit_valid <= 1'b0;
      viol      <= 1'b0;
      if (locked) begin
        if (tog && cnt >= EARLY) begin
          // mid-bit transition: its direction is the bit value
          bit_valid <= 1'b1;
          bit_val   <= lvl;
          cnt       <= '0;
        end else if (cnt == VIOLC - 1'b1) begin
          viol   <= 1'b1;
          locked <= 1'b0;
          seen   <= 1'b0;
          cnt    <= cnt + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (tog) begin
          // a full-bit spacing between transitions marks a mid-bit one
          if (seen && cnt >= EARLY && cnt <= LATE) begin
            locked    <= 1'b1;
            bit_valid <= 1'b1;
            bit_val   <= lvl;
          end
          seen <= 1'b1;
          cnt  <= '0;
        end else if (cnt != VIOLC) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_block_hunter.sv
module mdu_block_hunter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              viol,
  input  logic [WORD_W-1:0] pattern,
  output logic              word_valid,
  output logic [WORD_W-1:0] word,
  output logic              synced
);
  localparam int BCW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BCW-1:0] LASTB = BCW'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] sh_next;
  logic [BCW-1:0]    bcnt;

  assign sh_next = {shreg[WORD_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bcnt       <= '0;
      synced     <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (viol) begin
        synced <= 1'b0;
        bcnt   <= '0;
        shreg  <= '0;
      end else if (bit_valid) begin
        shreg <= sh_next;
        if (!synced) begin
          if (sh_next == pattern) begin
            synced     <= 1'b1;
            word_valid <= 1'b1;
            word       <= sh_next;
            bcnt       <= '0;
          end
        end else if (bcnt == LASTB) begin
          word_valid <= 1'b1;
          word       <= sh_next;
          bcnt       <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_word_fifo.sv
module mdu_word_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [W-1:0]              in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [W-1:0]              out_data,
  output logic [$clog2(DEPTH):0]    count,
  output logic                      overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr;
  logic [AW:0]  rd_ptr;
  logic         full;
  logic         push;
  logic         pop;

  assign full      = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign out_valid = (wr_ptr != rd_ptr);
  assign push      = in_valid && !full;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr[AW-1:0]];
  assign count     = wr_ptr - rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (in_valid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/mdu_uart_framer.sv
module mdu_uart_framer #(
  parameter int WORD_W   = 8,
  parameter int BAUD_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              utx,
  output logic              active
);
  import mdu_bridge_pkg::*;

  localparam int DW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [DW-1:0] LASTD = DW'(BAUD_DIV - 1);
  localparam logic [IW-1:0] LASTI = IW'(WORD_W - 1);

  tx_state_t         state;
  logic [DW-1:0]     dcnt;
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] rev;
  logic              cell_end;

  // bit reversal: the shifter sends its top bit first, so bit 0 lands there
  for (genvar g = 0; g < WORD_W; g++) begin : g_rev
    assign rev[g] = in_data[WORD_W-1-g];
  end

  assign in_ready = (state == TX_IDLE);
  assign active   = (state != TX_IDLE);
  assign cell_end = (dcnt == LASTD);

  always_comb begin
    case (state)
      TX_START: utx = 1'b0;
      TX_DATA:  utx = shreg[WORD_W-1];
      default:  utx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      dcnt  <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (in_valid) begin
            shreg <= rev;
            dcnt  <= '0;
            idx   <= '0;
            state <= TX_START;
          end
        end
        TX_START: begin
          if (cell_end) begin
            dcnt  <= '0;
            state <= TX_DATA;
          end else dcnt <= dcnt + 1'b1;
        end
        TX_DATA: begin
          if (cell_end) begin
            dcnt  <= '0;
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            if (idx == LASTI) state <= TX_STOP;
            else idx <= idx + 1'b1;
          end else dcnt <= dcnt + 1'b1;
        end
        default: begin
          if (cell_end) begin
            dcnt  <= '0;
            state <= TX_IDLE;
          end else dcnt <= dcnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/mdu_bridge.sv
module mdu_bridge #(
  parameter int OVS        = 16,
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int BAUD_DIV   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mline,
  input  logic [WORD_W-1:0] start_pattern,
  output logic              utx,
  output logic              sync_found,
  output logic              overflow,
  output logic              busy
);
  localparam int CNTW = $clog2(FIFO_DEPTH) + 1;

  logic              dec_bit_valid;
  logic              dec_bit_val;
  logic              dec_viol;
  logic              word_valid;
  logic [WORD_W-1:0] word;
  logic              q_valid;
  logic              q_ready;
  logic [WORD_W-1:0] q_data;
  logic [CNTW-1:0]   q_count;
  logic              tx_active;

  mdu_man_decoder #(.OVS(OVS)) u_dec (
    .clk(clk), .rst_n(rst_n), .line_i(mline),
    .bit_valid(dec_bit_valid), .bit_val(dec_bit_val), .viol(dec_viol)
  );

  mdu_block_hunter #(.WORD_W(WORD_W)) u_hunt (
    .clk(clk), .rst_n(rst_n),
    .bit_valid(dec_bit_valid), .bit_val(dec_bit_val), .viol(dec_viol),
    .pattern(start_pattern),
    .word_valid(word_valid), .word(word), .synced(sync_found)
  );

  mdu_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(word_valid), .in_data(word),
    .out_valid(q_valid), .out_ready(q_ready), .out_data(q_data),
    .count(q_count), .overflow(overflow)
  );

  mdu_uart_framer #(.WORD_W(WORD_W), .BAUD_DIV(BAUD_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(q_valid), .in_ready(q_ready), .in_data(q_data),
    .utx(utx), .active(tx_active)
  );

  assign busy = q_valid | tx_active;
endmodule

// File: rtl/mdu_bridge_chk.sv
module mdu_bridge_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNTW       = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            utx,
  input logic            sync_found,
  input logic            overflow,
  input logic            busy,
  input logic            bit_valid,
  input logic            viol,
  input logic            word_valid,
  input logic [CNTW-1:0] fifo_count
);
  localparam logic [CNTW-1:0] DEPTH_C = CNTW'(FIFO_DEPTH);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> utx);

  assert_viol_drops_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !sync_found);

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= DEPTH_C);

  assert_word_needs_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> sync_found);

  assert_bit_or_viol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && viol));

  assert_start_bit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(utx) |-> busy);
endmodule

bind mdu_bridge mdu_bridge_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .utx(utx), .sync_found(sync_found),
  .overflow(overflow), .busy(busy), .bit_valid(dec_bit_valid),
  .viol(dec_viol), .word_valid(word_valid), .fifo_count(q_count)
);

// File: tb/tb_mdu_bridge.sv
`timescale 1ns/1ps
module tb_mdu_bridge;
  localparam int OVS  = 16;
  localparam int BAUD = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mline = 1'b0;
  logic [7:0] start_pattern = 8'hC3;
  logic       utx, sync_found, overflow, busy;

  int checks = 0;
  int errors = 0;
  int rx_count = 0;
  bit ovf_mode = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  mdu_bridge #(.OVS(OVS), .WORD_W(8), .FIFO_DEPTH(16), .BAUD_DIV(BAUD)) dut (
    .clk(clk), .rst_n(rst_n), .mline(mline), .start_pattern(start_pattern),
    .utx(utx), .sync_found(sync_found), .overflow(overflow), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic man_bit(input logic b);
    mline = ~b;
    repeat (OVS/2) @(negedge clk);
    mline = b;
    repeat (OVS/2) @(negedge clk);
  endtask

  task automatic man_byte(input logic [7:0] b, input bit expect_out);
    for (int i = 7; i >= 0; i--) man_bit(b[i]);
    if (expect_out) exp_q.push_back(b);
  endtask

  task automatic line_idle(input int n);
    mline = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || busy) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (20) @(negedge clk);
  endtask

  // monitor: decodes UART characters and compares with the scoreboard
  initial begin
    logic [7:0] r;
    forever begin
      @(negedge clk);
      if (rst_n && utx == 1'b0) begin
        repeat (BAUD/2) @(negedge clk);
        check(utx == 1'b0, "R6 start cell", utx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BAUD) @(negedge clk);
          r[i] = utx;
        end
        repeat (BAUD) @(negedge clk);
        check(utx == 1'b1, "R6 stop cell", utx, 1);
        rx_count++;
        if (!ovf_mode) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3/R10 unexpected character", r, 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(r == e, "R2/R6/R7 character value", r, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(utx == 1'b1, "R1 utx", utx, 1);
    check(sync_found == 1'b0, "R1 sync_found", sync_found, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);

    // block with matching start byte
    line_idle(40);
    man_byte(8'hAA, 1'b0);
    man_byte(8'hC3, 1'b1);
    check(sync_found == 1'b1, "R4 sync after start byte", sync_found, 1);
    man_byte(8'h12, 1'b1);
    man_byte(8'hA5, 1'b1);
    man_byte(8'h00, 1'b1);
    man_byte(8'hFF, 1'b1);
    man_byte(8'h81, 1'b1);
    check(sync_found == 1'b1, "R4 sync held", sync_found, 1);
    check(busy == 1'b1, "R9 busy while queued", busy, 1);
    line_idle(64);
    check(sync_found == 1'b0, "R5 sync dropped at idle", sync_found, 0);
    drain();
    check(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
    check(busy == 1'b0, "R9 busy low when empty", busy, 0);
    check(utx == 1'b1, "R9 line idle high", utx, 1);

    // non-matching start byte is ignored
    start_pattern = 8'h5A;
    man_byte(8'hAA, 1'b0);
    man_byte(8'hC3, 1'b0);
    man_byte(8'h11, 1'b0);
    man_byte(8'h22, 1'b0);
    check(sync_found == 1'b0, "R10 no sync on other start", sync_found, 0);
    line_idle(64);
    repeat (400) @(negedge clk);
    check(busy == 1'b0, "R10 nothing queued", busy, 0);
    check(utx == 1'b1, "R10 line stays idle", utx, 1);

    // block cut short by a violation mid-word
    start_pattern = 8'hC3;
    man_byte(8'hAA, 1'b0);
    man_byte(8'hC3, 1'b1);
    man_bit(1'b1); man_bit(1'b0); man_bit(1'b1); man_bit(1'b1);
    line_idle(64);
    check(sync_found == 1'b0, "R5 sync dropped after truncation", sync_found, 0);
    drain();
    check(exp_q.size() == 0, "R5 partial word discarded", exp_q.size(), 0);
    check(overflow == 1'b0, "R8 no overflow yet", overflow, 0);

    // overflow: 41 words in faster than they drain
    ovf_mode = 1'b1;
    rx_count = 0;
    man_byte(8'hAA, 1'b0);
    man_byte(8'hC3, 1'b0);
    for (int i = 0; i < 40; i++) man_byte(8'(i), 1'b0);
    line_idle(64);
    drain();
    repeat (2 * 10 * BAUD) @(negedge clk);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    check(rx_count >= 17 && rx_count <= 40, "R8 words dropped when full", rx_count, 17);
    ovf_mode = 1'b0;

    // after overflow: normal delivery, flag sticky
    man_byte(8'hAA, 1'b0);
    man_byte(8'hC3, 1'b1);
    man_byte(8'h3C, 1'b1);
    man_byte(8'h96, 1'b1);
    line_idle(64);
    drain();
    check(exp_q.size() == 0, "R7 delivery after overflow", exp_q.size(), 0);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule